// File: doc/BRIEF.md
# Synchronous Burst Read Latency Controller

This block is the read engine on the memory side of a flash-like device that supports synchronous burst reads. A burst begins on a clock edge where chip enable is active and the address-valid strobe is low. On that edge the engine captures the start address and the configuration inputs. It then waits out a programmable initial latency. After that it delivers one word per clock, and the word address wraps inside an aligned group of 8, 16 or 32 words.

The array is divided into 64-word segments. The word whose low six address bits are 3Eh sits at a segment boundary. Each time the burst emits that word, the engine holds it on the data output for two more clocks and drops ready for those clocks. A burst that starts on a boundary pays two extra initial wait states instead. Address zero also counts as a boundary for this purpose.

Words are fetched through a synchronous read port with one clock of read latency. Ready and data appear at the pins only while both chip enable and output enable are active.

Top module: `burst_read_ctrl`

## Requirements
- R1: A burst starts on a rising clock edge where `ce_n` and `avd_n` are both low. On that edge `addr`, `cfg_blen`, `cfg_wait` and `cfg_ps` are captured. Changes to these inputs later in the burst have no effect.
- R2: The total initial latency L counts edges after the start edge. Ready stays low for edges 1 to L-1, and the start word appears with ready high after edge L. L = W + P + B, where W, P and B are set by R3, R4 and R5.
- R3: `cfg_wait` is 3 bits. Codes 2 to 7 give W equal to the code. Codes 0 and 1 give W = 2.
- R4: When `cfg_ps` is 1 at the start edge, P = 1. Otherwise P = 0.
- R5: B = 2 when the start address has low six bits equal to 3Eh, or when the start address is entirely zero. Otherwise B = 0.
- R6: After the first word, one new word per clock is presented with ready high. The next word address increments the low G bits and keeps the upper bits, so the burst wraps inside its aligned group. `cfg_blen` code 00 gives G = 3 (8 words), 01 gives G = 4 (16 words), and 10 or 11 gives G = 5 (32 words).
- R7: After a word whose address has low six bits equal to 3Eh is presented with ready high, the next two clocks hold that word on `dout` with ready low. The following word comes on the clock after that.
- R8: While `ce_n` or `oe_n` is high, `rdy` and `dout` read 0 and `dout_en` is 0. While only `oe_n` is high, sequencing continues unchanged.
- R9: A rising clock edge with `ce_n` high ends any burst. Ready stays low afterwards until a new start.
- R10: While reset is asserted and after it is released, `rdy` and `dout` read 0 until a burst is started.
- R11: `mem_addr` carries the word address being fetched. The start address is on it right after the start edge. `mem_rdata` is expected to hold that word's data one clock after the address is presented.
- R12: Each data word on `dout` is the `mem_rdata` returned for the address of that burst position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| avd_n | input | 1 | Address-valid strobe, active low |
| addr | input | AW | Burst start word address |
| cfg_blen | input | 2 | Wrap group size code |
| cfg_wait | input | 3 | Base initial latency code |
| cfg_ps | input | 1 | Power-saving extra wait enable |
| mem_addr | output | AW | Read address to the word store |
| mem_rdata | input | DW | Read data, one clock after mem_addr |
| rdy | output | 1 | Data valid / ready |
| dout | output | DW | Burst data |
| dout_en | output | 1 | Output drive enable |

## Verification
The bench sweeps every group size, every latency code including the two low codes that clamp to 2, and both power-saving settings. It runs each combination from start addresses at zero, on a boundary, just before a boundary, in a segment with no boundary, and in a boundary segment with high address bits set.

A design that counted latency from the wrong edge, or that forgot the clamp, the power-saving cycle or the start-boundary cycles, would show ready one clock early or late. A design that wrapped on the wrong group, or carried into the upper address bits, would put wrong data on the pins. A design that stalled only once at 3Eh, or stalled on the start word but not in mid-burst, would put the next word on the pins too early.

The bench also changes the configuration and address right after the start edge, pulses output enable in mid-burst, and drops chip enable. These checks catch late sampling, sequencing that freezes while the outputs are disabled, and a burst that resumes after it was ended.

// File: rtl/burst_rd_pkg.sv
package burst_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_STREAM = 2'd2
  } brd_state_e;

endpackage

// File: rtl/brd_latency.sv
module brd_latency #(
  parameter int AW       = 22,
  parameter int SEG_BITS = 6,
  parameter int WAIT_W   = 3,
  parameter int CW       = 4
) (
  input  logic [AW-1:0]     start_addr,
  input  logic [WAIT_W-1:0] wait_cfg,
  input  logic              ps_en,
  output logic [CW-1:0]     pre_issue
);
  localparam logic [SEG_BITS-1:0] BND_LOW = ~SEG_BITS'(1);

  logic [WAIT_W-1:0] base;
  logic              on_bnd;
  logic [CW-1:0]     total;

  always_comb begin
    base      = (wait_cfg < WAIT_W'(2)) ? WAIT_W'(2) : wait_cfg;
    on_bnd    = (start_addr[SEG_BITS-1:0] == BND_LOW) || (start_addr == '0);
    total     = CW'(base) + CW'(ps_en) + (on_bnd ? CW'(2) : CW'(0));
    // issue delay into the two-stage fetch pipeline
    pre_issue = total - CW'(2);
  end

  // R2: latency stays within clamp plus both additions
  always_comb begin
    p_lat_range_r2: assert (total >= CW'(2) && total <= CW'((1 << WAIT_W) + 2));
  end

endmodule

// File: rtl/brd_wrap_next.sv
module brd_wrap_next #(
  parameter int AW            = 22,
  parameter int BLEN_W        = 2,
  parameter int MIN_GRP_BITS  = 3,
  parameter int NUM_LEN       = 3
) (
  input  logic [AW-1:0]     cur,
  input  logic [BLEN_W-1:0] blen,
  output logic [AW-1:0]     nxt
);
  logic [AW-1:0] cand [NUM_LEN];

  for (genvar gi = 0; gi < NUM_LEN; gi++) begin : g_len
    localparam int            GB  = MIN_GRP_BITS + gi;
    localparam logic [AW-1:0] MSK = AW'((1 << GB) - 1);
    assign cand[gi] = (cur & ~MSK) | ((cur + AW'(1)) & MSK);
  end

  always_comb begin
    nxt = cand[NUM_LEN-1];
    for (int i = 0; i < NUM_LEN; i++) begin
      if (int'(blen) == i) nxt = cand[i];
    end
  end

endmodule

// File: rtl/brd_out_gate.sv
module brd_out_gate #(
  parameter int DW = 16
) (
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          rdy_q,
  input  logic [DW-1:0] data_q,
  output logic          drive,
  output logic          rdy_pin,
  output logic [DW-1:0] data_pin
);
  always_comb begin
    drive    = !ce_n && !oe_n;
    rdy_pin  = drive && rdy_q;
    data_pin = drive ? data_q : '0;
  end

endmodule

// File: rtl/burst_read_ctrl.sv
module burst_read_ctrl
  import burst_rd_pkg::*;
#(
  parameter int AW       = 22,
  parameter int DW       = 16,
  parameter int SEG_BITS = 6,
  parameter int WAIT_W   = 3,
  parameter int BLEN_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              avd_n,
  input  logic [AW-1:0]     addr,
  input  logic [BLEN_W-1:0] cfg_blen,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic              cfg_ps,
  output logic [AW-1:0]     mem_addr,
  input  logic [DW-1:0]     mem_rdata,
  output logic              rdy,
  output logic [DW-1:0]     dout,
  output logic              dout_en
);
  localparam int PRE_MAX = (1 << WAIT_W) + 1;
  localparam int CW      = $clog2(PRE_MAX + 1);
  localparam logic [SEG_BITS-1:0] BND_LOW = ~SEG_BITS'(1);

  brd_state_e        state_q;
  logic [CW-1:0]     cnt_q;
  logic [AW-1:0]     ptr_q;
  logic              iss_q;
  logic              iss_d1_q;
  logic              hold_q;
  logic [BLEN_W-1:0] blen_q;
  logic              rdy_q;
  logic [DW-1:0]     dout_q;

  logic [CW-1:0]     pre_issue;
  logic [AW-1:0]     ptr_nxt;
  logic              start;
  logic              ptr_at_bnd;

  assign start      = !ce_n && !avd_n;
  assign ptr_at_bnd = (ptr_q[SEG_BITS-1:0] == BND_LOW);
  assign mem_addr   = ptr_q;

  brd_latency #(
    .AW(AW), .SEG_BITS(SEG_BITS), .WAIT_W(WAIT_W), .CW(CW)
  ) u_lat (
    .start_addr (addr),
    .wait_cfg   (cfg_wait),
    .ps_en      (cfg_ps),
    .pre_issue  (pre_issue)
  );

  brd_wrap_next #(
    .AW(AW), .BLEN_W(BLEN_W), .MIN_GRP_BITS(3), .NUM_LEN(3)
  ) u_wrap (
    .cur  (ptr_q),
    .blen (blen_q),
    .nxt  (ptr_nxt)
  );

  brd_out_gate #(.DW(DW)) u_gate (
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .rdy_q    (rdy_q),
    .data_q   (dout_q),
    .drive    (dout_en),
    .rdy_pin  (rdy),
    .data_pin (dout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      ptr_q    <= '0;
      iss_q    <= 1'b0;
      iss_d1_q <= 1'b0;
      hold_q   <= 1'b0;
      blen_q   <= '0;
      rdy_q    <= 1'b0;
      dout_q   <= '0;
    end else if (ce_n) begin
      state_q  <= ST_IDLE;
      iss_q    <= 1'b0;
      iss_d1_q <= 1'b0;
      hold_q   <= 1'b0;
      rdy_q    <= 1'b0;
    end else if (start) begin
      ptr_q    <= addr;
      blen_q   <= cfg_blen;
      hold_q   <= 1'b0;
      iss_d1_q <= 1'b0;
      rdy_q    <= 1'b0;
      if (pre_issue == '0) begin
        iss_q   <= 1'b1;
        state_q <= ST_STREAM;
      end else begin
        iss_q   <= 1'b0;
        cnt_q   <= pre_issue;
        state_q <= ST_WAIT;
      end
    end else begin
      iss_d1_q <= iss_q;
      rdy_q    <= iss_d1_q;
      if (iss_d1_q) dout_q <= mem_rdata;
      case (state_q)
        ST_WAIT: begin
          if (cnt_q == CW'(1)) begin
            iss_q   <= 1'b1;
            state_q <= ST_STREAM;
          end else begin
            cnt_q <= cnt_q - CW'(1);
            iss_q <= 1'b0;
          end
        end
        ST_STREAM: begin
          if (hold_q) begin
            hold_q <= 1'b0;
            iss_q  <= 1'b0;
          end else if (iss_q && ptr_at_bnd) begin
            hold_q <= 1'b1;
            iss_q  <= 1'b0;
          end else begin
            ptr_q <= ptr_nxt;
            iss_q <= 1'b1;
          end
        end
        default: iss_q <= 1'b0;
      endcase
    end
  end

  logic [AW-1:0] grp_mask_chk;
  always_comb begin
    if (blen_q == BLEN_W'(0))      grp_mask_chk = AW'(7);
    else if (blen_q == BLEN_W'(1)) grp_mask_chk = AW'(15);
    else                           grp_mask_chk = AW'(31);
  end

  // R7: the presented word does not move while ready is low
  p_hold_data_r7: assert property (@(posedge clk) disable iff (rst)
    !rdy_q |-> $stable(dout_q));

  // R6: consecutive issued addresses step within the aligned group
  p_wrap_step_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STREAM && iss_q && !hold_q && !ptr_at_bnd && !ce_n && avd_n)
    |=> (iss_q && ((ptr_q & ~grp_mask_chk) == ($past(ptr_q) & ~grp_mask_chk))
         && ((ptr_q & grp_mask_chk) == (($past(ptr_q) + AW'(1)) & grp_mask_chk))));

  // R7: a boundary word is followed by a fetch bubble
  p_bnd_bubble_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STREAM && iss_q && !hold_q && ptr_at_bnd && !ce_n && avd_n)
    |=> !iss_q);

  // R9: chip enable high returns the engine to idle
  p_ce_idle_r9: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> (state_q == ST_IDLE && !rdy_q && !iss_q));

endmodule

// File: tb/test_burst_read_ctrl.sv
module test_burst_read_ctrl;
  localparam int AW = 22;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          ce_n, oe_n, avd_n;
  logic [AW-1:0] addr;
  logic [1:0]    cfg_blen;
  logic [2:0]    cfg_wait;
  logic          cfg_ps;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata = '0;
  logic          rdy;
  logic [DW-1:0] dout;
  logic          dout_en;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  burst_read_ctrl i_burst_read_ctrl (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .avd_n(avd_n),
    .addr(addr), .cfg_blen(cfg_blen), .cfg_wait(cfg_wait), .cfg_ps(cfg_ps),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .rdy(rdy), .dout(dout), .dout_en(dout_en)
  );

  function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
    return a[15:0] ^ {a[21:16], a[21:16], 4'hA};
  endfunction

  // synchronous word store model, one clock read latency (R11)
  always @(posedge clk) mem_rdata <= word_of(mem_addr);

  function automatic logic [AW-1:0] step_of(input logic [AW-1:0] a, input int bl);
    int gb;
    logic [AW-1:0] m;
    gb = (bl == 0) ? 3 : (bl == 1) ? 4 : 5;
    m  = AW'((1 << gb) - 1);
    return (a & ~m) | ((a + AW'(1)) & m);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_burst(input logic [AW-1:0] a, input int bl, input int wt, input int ps);
    int lat, bub;
    bit bnd, gate, exp_rdy;
    logic [AW-1:0] w;
    string ltag;
    bnd = (a[5:0] == 6'h3E) || (a == '0);
    lat = ((wt < 2) ? 2 : wt) + ps + (bnd ? 2 : 0);
    ltag = bnd ? "R5" : (ps != 0) ? "R4" : (wt < 2) ? "R3" : "R2";
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; avd_n = 1'b0;
    addr = a; cfg_blen = 2'(bl); cfg_wait = 3'(wt); cfg_ps = 1'(ps);
    @(posedge clk);
    @(negedge clk);
    avd_n = 1'b1; addr = ~a; cfg_blen = 2'(bl + 1); cfg_wait = ~3'(wt); cfg_ps = ~1'(ps);
    chk("R11 mem_addr", 32'(mem_addr), 32'(a));
    w = a; bub = 0;
    for (int k = 1; k <= lat + 40; k++) begin
      gate = (bl == 1) && (k == lat + 4);
      oe_n = gate;
      if (k < lat) exp_rdy = 1'b0;
      else if (k == lat) begin
        w = a; exp_rdy = 1'b1; bub = (w[5:0] == 6'h3E) ? 2 : 0;
      end else if (bub > 0) begin
        exp_rdy = 1'b0; bub--;
      end else begin
        w = step_of(w, bl); exp_rdy = 1'b1; bub = (w[5:0] == 6'h3E) ? 2 : 0;
      end
      @(posedge clk);
      @(negedge clk);
      if (gate) begin
        chk("R8 rdy gated", 32'(rdy), 0);
        chk("R8 dout gated", 32'(dout), 0);
        chk("R8 dout_en", 32'(dout_en), 0);
      end else if (k < lat) begin
        chk({ltag, " latency rdy"}, 32'(rdy), 0);
      end else if (k == lat) begin
        chk({ltag, " first rdy"}, 32'(rdy), 1);
        chk("R1 R12 first word", 32'(dout), 32'(word_of(w)));
      end else if (!exp_rdy) begin
        chk("R7 stall rdy", 32'(rdy), 0);
        chk("R7 stall word", 32'(dout), 32'(word_of(w)));
      end else begin
        chk("R6 stream rdy", 32'(rdy), 1);
        chk("R6 R12 stream word", 32'(dout), 32'(word_of(w)));
      end
    end
    oe_n = 1'b0; ce_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R8 ce off dout_en", 32'(dout_en), 0);
    ce_n = 1'b0; avd_n = 1'b1;
    for (int j = 0; j < 3; j++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R9 ended rdy", 32'(rdy), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [AW-1:0] starts [6];
    starts[0] = 22'h000000; starts[1] = 22'h00003E; starts[2] = 22'h00003B;
    starts[3] = 22'h000045; starts[4] = 22'h15A7E;  starts[5] = 22'h0000C0;
    rst = 1'b1; ce_n = 1'b0; oe_n = 1'b0; avd_n = 1'b1;
    addr = '0; cfg_blen = '0; cfg_wait = '0; cfg_ps = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset rdy", 32'(rdy), 0);
    chk("R10 reset dout", 32'(dout), 0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R10 post reset rdy", 32'(rdy), 0);
    chk("R10 post reset dout", 32'(dout), 0);
    for (int bl = 0; bl < 3; bl++)
      for (int wt = 0; wt < 8; wt++)
        for (int ps = 0; ps < 2; ps++)
          for (int s = 0; s < 6; s++)
            run_burst(starts[s], bl, wt, ps);
    run_burst(22'h00013C, 3, 4, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule